// File: doc/BRIEF.md
# Four-Way Write-Through Cache Controller

This block is a unified instruction-and-data cache controller. It sits between a 32-bit processor request port and a 32-bit external memory bus. Lookups are made in a four-way set-associative store of 128 sets, with 16-byte lines, for 8 KB in total. A read that hits returns data in the cycle it is presented. A cacheable read miss starts a four-beat burst that fetches the whole line. A non-cacheable read miss is passed to the bus as one ordinary read. Every write goes to the bus. A write that hits also merges its enabled bytes into the cached word.

The processor holds `cpu_req_i` and its qualifiers stable until `cpu_ready_o` is high. The request completes at the clock edge where ready is seen. Bus requests use the same hold-until-acknowledge rule: `bus_req_o` stays high, and each `bus_ack_i` closes one data beat. During a line fill the requested word goes back to the processor in the cycle its beat arrives. All other requests wait until the last beat has been written and the line has been marked valid.

Top module: `wt_cache`

## Requirements
- R1: A read whose line is present raises `cpu_ready_o` in the same cycle as the request, with the cached word on `cpu_rdata_o`, and `bus_req_o` stays low.
- R2: In the cycle after a cacheable read miss, `bus_req_o` rises with `bus_burst_o`=1, `bus_we_o`=0 and `bus_be_o`=4'hF. `bus_addr_o` walks the line words 0,1,2,3 (bits [3:2]) in order, advancing on each `bus_ack_i`. `bus_req_o` falls in the cycle after the fourth acknowledge.
- R3: During a fill, `cpu_ready_o` is high only in the acknowledge cycle of the beat whose index equals the request's address bits [3:2], with `bus_rdata_i` passed to `cpu_rdata_o`. It stays low in wait-state cycles and on every other beat.
- R4: A line becomes valid only after its fourth beat. A read of it presented in the cycle after the fill then hits.
- R5: A non-cacheable read miss gives one bus read with `bus_burst_o`=0 at the word-aligned address, and completes on its acknowledge. It allocates nothing, so repeating the read misses again.
- R6: Every write, hit or miss, gives one bus write in the cycle after the request, carrying the word address, byte enables and data. The write completes on its acknowledge.
- R7: A write hit replaces only the bytes whose enables are set in the cached word. A write miss allocates no line.
- R8: On a fill the victim is the lowest-numbered invalid way of the set. If all four ways are valid, a 3-bit tree pseudo-LRU chooses the victim. Read hits and completed fills mark the way as most recently used.
- R9: A high `flush_i` at a clock edge invalidates every line. Reset does the same. After either, any read misses.
- R10: The address is split as follows: bits [3:2] select the word, bits [10:4] select the set, and bits [31:11] form the tag. Two addresses that share a set and word but differ in tag do not alias.
- R11: `cpu_ready_o` is high only while `cpu_req_i` is high, and processor addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Word-aligned byte address |
| cpu_be_i | input | 4 | Byte enables for writes |
| cpu_wdata_i | input | 32 | Write data |
| cpu_cacheable_i | input | 1 | Region may be allocated on a read miss |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | 32 | Read data, valid with ready |
| bus_req_o | output | 1 | Bus transaction active |
| bus_we_o | output | 1 | Bus write |
| bus_burst_o | output | 1 | Four-beat line burst |
| bus_addr_o | output | 32 | Current beat byte address |
| bus_be_o | output | 4 | Bus byte enables |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Beat accepted or data valid |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
The hardest case to reach is a victim chosen by the pseudo-LRU tree rather than by an invalid way. The stimulus fills all four ways of one set with five tags that alias on bits [10:4]. It reads an older line again to move the tree, and then forces a fifth fill. A reference model then predicts which earlier line must miss. Fill timing is also probed with the processor still holding its request after the early word. One burst inserts a wait state between beats, which shows that no other request is served before the line turns valid.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BE_W       = DATA_W / 8;
  localparam int unsigned BYTE_OFF   = $clog2(BE_W);
  localparam int unsigned WAYS       = 4;
  localparam int unsigned WAY_W      = $clog2(WAYS);
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned WORD_W     = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SINGLE} st_e;

  // tree: t[0] root (1 = go right), t[1] left pair, t[2] right pair
  function automatic logic [WAY_W-1:0] plru_victim(logic [2:0] t, logic [WAYS-1:0] vld);
    if (!vld[0]) return 2'd0;
    if (!vld[1]) return 2'd1;
    if (!vld[2]) return 2'd2;
    if (!vld[3]) return 2'd3;
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] plru_touch(logic [2:0] t, logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
  import wtc_pkg::*;
#(
  parameter int unsigned SETS  = 128,
  parameter int unsigned IDX_W = $clog2(SETS),
  parameter int unsigned TAG_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAYS-1:0]  valid_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [WAYS-1:0] hit_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_sel;

    assign wr_sel = wr_en_i && (wr_way_i == WAY_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q <= '0;
      else if (flush_i) vld_q <= '0;   // flush wins over a finishing fill
      else if (wr_sel)  vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_sel) tag_q[wr_idx_i] <= wr_tag_i;
    end

    assign valid_o[g] = vld_q[lk_idx_i];
    assign hit_vec[g] = vld_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

    a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (vld_q == '0));
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign hit_o = |hit_vec;

  // R10: one tag may live in only one way of a set
  a_r10_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store
  import wtc_pkg::*;
#(
  parameter int unsigned SETS  = 128,
  parameter int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned AW    = WAY_W + IDX_W + WORD_W;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_a, wr_a;

  assign rd_a    = {rd_way_i, rd_idx_i, rd_word_i};
  assign wr_a    = {wr_way_i, wr_idx_i, wr_word_i};
  assign rdata_o = mem_q[rd_a];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) mem_q[wr_a][8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/wtc_plru.sv
module wtc_plru
  import wtc_pkg::*;
#(
  parameter int unsigned SETS  = 128,
  parameter int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en_i) begin
      tree_q[upd_idx_i] <= plru_touch(tree_q[upd_idx_i], upd_way_i);
    end
  end

  assign victim_o = plru_victim(tree_q[idx_i], valid_i);

  // R8: never evict a valid line while an invalid way exists
  a_r8_invalid_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i != '1) |-> !valid_i[victim_o]);
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int unsigned SETS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_cacheable_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_burst_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BE_W-1:0]   bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WA_W  = ADDR_W - BYTE_OFF;
  localparam int unsigned TAG_W = WA_W - IDX_W - WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  st_e st_q, st_d;
  logic [WA_W-1:0]   lat_wa_q;
  logic              lat_we_q;
  logic [BE_W-1:0]   lat_be_q;
  logic [DATA_W-1:0] lat_wd_q;
  logic [WAY_W-1:0]  lat_way_q;
  logic [WORD_W-1:0] beat_q;

  logic [WA_W-1:0]   lk_wa;
  logic [WORD_W-1:0] lk_word;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [WAYS-1:0]   set_valid;
  logic [DATA_W-1:0] arr_rdata;
  logic              rd_hit, fill_ack, fill_last, wr_hit;

  // lookup follows the live request when idle, the held one otherwise
  assign lk_wa   = (st_q == ST_IDLE) ? cpu_addr_i[ADDR_W-1:BYTE_OFF] : lat_wa_q;
  assign lk_word = lk_wa[WORD_W-1:0];
  assign lk_idx  = lk_wa[WORD_W +: IDX_W];
  assign lk_tag  = lk_wa[WA_W-1 -: TAG_W];

  assign rd_hit    = (st_q == ST_IDLE) && cpu_req_i && !cpu_we_i && hit;
  assign fill_ack  = (st_q == ST_FILL) && bus_ack_i;
  assign fill_last = fill_ack && (beat_q == LAST_BEAT);
  assign wr_hit    = (st_q == ST_SINGLE) && lat_we_q && bus_ack_i && hit;

  wtc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_idx_i  (lk_idx),
    .lk_tag_i  (lk_tag),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .valid_o   (set_valid),
    .wr_en_i   (fill_last),
    .wr_idx_i  (lk_idx),
    .wr_way_i  (lat_way_q),
    .wr_tag_i  (lk_tag)
  );

  wtc_data_store #(.SETS(SETS), .IDX_W(IDX_W)) u_data (
    .clk_i     (clk_i),
    .rd_way_i  (hit_way),
    .rd_idx_i  (lk_idx),
    .rd_word_i (lk_word),
    .rdata_o   (arr_rdata),
    .wr_en_i   (fill_ack || wr_hit),
    .wr_way_i  (fill_ack ? lat_way_q : hit_way),
    .wr_idx_i  (lk_idx),
    .wr_word_i (fill_ack ? beat_q : lk_word),
    .wr_be_i   (fill_ack ? {BE_W{1'b1}} : lat_be_q),
    .wr_data_i (fill_ack ? bus_rdata_i : lat_wd_q)
  );

  wtc_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (lk_idx),
    .valid_i   (set_valid),
    .victim_o  (victim),
    .upd_en_i  (rd_hit || fill_last),
    .upd_idx_i (lk_idx),
    .upd_way_i (rd_hit ? hit_way : lat_way_q)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req_i) begin
          if (cpu_we_i)             st_d = ST_SINGLE;
          else if (!hit)            st_d = cpu_cacheable_i ? ST_FILL : ST_SINGLE;
        end
      end
      ST_FILL:   if (fill_last) st_d = ST_IDLE;
      ST_SINGLE: if (bus_ack_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      lat_wa_q  <= '0;
      lat_we_q  <= 1'b0;
      lat_be_q  <= '0;
      lat_wd_q  <= '0;
      lat_way_q <= '0;
      beat_q    <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_IDLE) && cpu_req_i) begin
        lat_wa_q  <= cpu_addr_i[ADDR_W-1:BYTE_OFF];
        lat_we_q  <= cpu_we_i;
        lat_be_q  <= cpu_be_i;
        lat_wd_q  <= cpu_wdata_i;
        lat_way_q <= victim;
        beat_q    <= '0;
      end else if (fill_ack) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign cpu_ready_o = rd_hit
                    || (fill_ack && (beat_q == lat_wa_q[WORD_W-1:0]))
                    || ((st_q == ST_SINGLE) && bus_ack_i);
  assign cpu_rdata_o = (st_q == ST_IDLE) ? arr_rdata : bus_rdata_i;

  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_SINGLE) && lat_we_q;
  assign bus_burst_o = (st_q == ST_FILL);
  assign bus_be_o    = bus_we_o ? lat_be_q : {BE_W{1'b1}};
  assign bus_wdata_o = lat_wd_q;
  assign bus_addr_o  = {lat_wa_q[WA_W-1:WORD_W],
                        (st_q == ST_FILL) ? beat_q : lat_wa_q[WORD_W-1:0],
                        {BYTE_OFF{1'b0}}};

  a_r11_ready_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);
  a_r11_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |-> (cpu_addr_i[BYTE_OFF-1:0] == '0));
  a_r1_hit_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && !bus_req_o) |-> !cpu_we_i);
  a_r6_write_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && cpu_we_i) |-> (bus_req_o && bus_we_o && bus_ack_i));
  a_r2_burst_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_burst_o && bus_ack_i && (bus_addr_o[3:2] != 2'd3))
      |=> (bus_req_o && (bus_addr_o[3:2] == 2'($past(bus_addr_o[3:2]) + 2'd1))));
  a_r2_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_burst_o && bus_ack_i && (bus_addr_o[3:2] == 2'd3)) |=> !bus_req_o);
  a_r5_single_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_burst_o && bus_ack_i) |=> !bus_req_o);
endmodule

// File: tb/wt_cache_tb.sv
module wt_cache_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush = 1'b0;
  logic        req = 1'b0, we = 1'b0, cach = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        breq, bwe, bburst, back = 1'b0;
  logic [31:0] baddr, bwdata, brdata = '0;
  logic [3:0]  bbe;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wt_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_be_i(be),
    .cpu_wdata_i(wdata), .cpu_cacheable_i(cach),
    .cpu_ready_o(ready), .cpu_rdata_o(rdata),
    .bus_req_o(breq), .bus_we_o(bwe), .bus_burst_o(bburst), .bus_addr_o(baddr),
    .bus_be_o(bbe), .bus_wdata_o(bwdata), .bus_ack_i(back), .bus_rdata_i(brdata)
  );

  // behavioural reference: cache contents, tree state, backing memory
  bit          m_v [4][128];
  logic [20:0] m_t [4][128];
  logic [31:0] m_d [4][128][4];
  logic [2:0]  m_p [128];
  logic [31:0] memw [logic [31:0]];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (memw.exists(a)) return memw[a];
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic int m_lookup(logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_v[w][a[10:4]] && m_t[w][a[10:4]] == a[31:11]) return w;
    return -1;
  endfunction

  function automatic void m_touch(int s, int w);
    if (w < 2) begin m_p[s][0] = 1'b1; m_p[s][1] = (w == 0); end
    else       begin m_p[s][0] = 1'b0; m_p[s][2] = (w == 2); end
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < 4; w++) if (!m_v[w][s]) return w;
    if (m_p[s][0]) return m_p[s][2] ? 3 : 2;
    return m_p[s][1] ? 1 : 0;
  endfunction

  function automatic void m_clear(bit tree);
    for (int w = 0; w < 4; w++) for (int s = 0; s < 128; s++) m_v[w][s] = 1'b0;
    if (tree) for (int s = 0; s < 128; s++) m_p[s] = 3'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_req();
    @(negedge clk); back = 1'b0; req = 1'b0; #2;
    chk("R11 ready low without request", 32'(ready), 32'd0);
    chk("R2 bus idle after transfer", 32'(breq), 32'd0);
  endtask

  task automatic do_read(logic [31:0] a, logic c, bit gap);
    int s, wd, w, v;
    logic [31:0] base;
    s = int'(a[10:4]); wd = int'(a[3:2]);
    base = {a[31:4], 4'h0};
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a; cach = c; be = 4'hF; #2;
    w = m_lookup(a);
    chk("R10 hit decision", 32'(ready), 32'(w >= 0));
    if (w >= 0) begin
      chk("R1 hit data", rdata, m_d[w][s][wd]);
      chk("R1 no bus on hit", 32'(breq), 32'd0);
      m_touch(s, w);
    end else if (c) begin
      v = m_victim(s);
      @(negedge clk); #2;
      chk("R2 burst request", {breq, bburst, bwe, bbe}, {1'b1, 1'b1, 1'b0, 4'hF});
      chk("R2 first beat address", baddr, base);
      chk("R3 no ready in address cycle", 32'(ready), 32'd0);
      for (int k = 0; k < 4; k++) begin
        if (gap && k == 2) begin
          @(negedge clk); back = 1'b0; #2;
          chk("R3 no ready in wait state", 32'(ready), 32'd0);
          chk("R2 request held in wait state", 32'(breq), 32'd1);
        end
        @(negedge clk); back = 1'b1; brdata = mem_rd(base + 32'(4 * k)); #2;
        m_d[v][s][k] = brdata;
        chk("R2 beat address", baddr, base + 32'(4 * k));
        chk("R3 ready only on requested beat", 32'(ready), 32'(k == wd));
        if (k == wd) chk("R3 early word data", rdata, brdata);
      end
      m_v[v][s] = 1'b1; m_t[v][s] = a[31:11]; m_touch(s, v);
      @(negedge clk); back = 1'b0; #2;
      chk("R2 request drops after fourth beat", 32'(breq), 32'd0);
      chk("R4 line valid after fill", 32'(ready), 32'd1);
      chk("R4 data after fill", rdata, m_d[v][s][wd]);
      m_touch(s, v);
    end else begin
      @(negedge clk); #2;
      chk("R5 single read request", {breq, bburst, bwe}, {1'b1, 1'b0, 1'b0});
      chk("R5 word address", baddr, {a[31:2], 2'b00});
      @(negedge clk); back = 1'b1; brdata = mem_rd(a); #2;
      chk("R5 ready on ack", 32'(ready), 32'd1);
      chk("R5 data", rdata, brdata);
    end
    finish_req();
  endtask

  task automatic do_write(logic [31:0] a, logic [3:0] b, logic [31:0] d);
    int w;
    logic [31:0] old;
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d; cach = 1'b1; #2;
    chk("R6 write not ready at once", 32'(ready), 32'd0);
    @(negedge clk); #2;
    chk("R6 bus write", {breq, bwe, bburst, bbe}, {1'b1, 1'b1, 1'b0, b});
    chk("R6 write address", baddr, a);
    chk("R6 write data", bwdata, d);
    chk("R6 wait for ack", 32'(ready), 32'd0);
    @(negedge clk); back = 1'b1; #2;
    chk("R6 ready on ack", 32'(ready), 32'd1);
    old = mem_rd(a);
    for (int i = 0; i < 4; i++) if (b[i]) old[8*i +: 8] = d[8*i +: 8];
    memw[a] = old;
    w = m_lookup(a);
    if (w >= 0)
      for (int i = 0; i < 4; i++)
        if (b[i]) m_d[w][a[10:4]][a[3:2]][8*i +: 8] = d[8*i +: 8];
    finish_req();
    we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clear(1'b1);
    repeat (2) @(negedge clk);
    #2;
    chk("R9 reset ready", 32'(ready), 32'd0);
    chk("R9 reset bus", 32'(breq), 32'd0);
    rst_ni = 1'b1;

    do_read(32'h0000_1234, 1'b1, 1'b0);   // fill, word 1
    do_read(32'h0000_1230, 1'b1, 1'b0);   // R1 hits
    do_read(32'h0000_123C, 1'b1, 1'b0);
    do_read(32'h0008_0040, 1'b0, 1'b0);   // R5 non-cacheable twice
    do_read(32'h0008_0040, 1'b0, 1'b0);
    do_write(32'h0000_1238, 4'b0101, 32'hDEAD_BEEF);  // R7 hit merge
    do_read(32'h0000_1238, 1'b1, 1'b0);
    do_write(32'h0002_0000, 4'b1111, 32'hCAFE_0001);  // R7 miss, no allocate
    do_read(32'h0002_0000, 1'b1, 1'b1);   // fill with wait state, word 0

    // R8: five tags aliasing on set 5
    for (int k = 0; k < 4; k++) do_read(32'h0010_0050 + 32'(k * 32'h800) + 32'h0C, 1'b1, 1'b0);
    do_read(32'h0010_0050, 1'b1, 1'b0);
    do_read(32'h0010_0050 + 32'h2000, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) do_read(32'h0010_0054 + 32'(k * 32'h800), 1'b1, 1'b0);

    // R9 flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    m_clear(1'b0);
    do_read(32'h0000_1230, 1'b1, 1'b0);
    do_read(32'h0000_1230, 1'b1, 1'b0);

    // R9 reset mid-run
    @(negedge clk); rst_ni = 1'b0; #2;
    chk("R9 reset during run", 32'(breq), 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    m_clear(1'b1);
    do_read(32'h0000_1238, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule